// File: doc/BRIEF.md
# Posted Write Drain Engine for a 32-bit PCI Master

This block holds memory writes that the host side has already completed and plays them out onto a 32-bit multiplexed PCI address/data bus, acting as bus master. The host side pushes entries into an internal queue. Each entry carries a doubleword address, 32 bits of data and four byte enables. The engine opens a memory-write transaction with an address phase and then presents the queued data one doubleword at a time. An entry leaves the queue only when the target accepts its data.

If the entry that follows in the queue targets the next doubleword address, the engine keeps the transaction open and continues it as a burst. If it does not, the engine closes the transaction and begins a new one from idle. Bus parking is represented by the grant input. When grant is already present and the bus is idle, the engine starts without raising its request. All PCI control signals at this boundary are active high; an external pad stage applies the bus polarity.

Top module: `pwd_drain_engine`

## Requirements
- R1: When the queue is non-empty and grant and bus-idle are both high while the engine is idle, the address phase starts on the next clock and the request output is never asserted.
- R2: When grant or bus-idle is low, the engine asserts request and waits. The address phase starts on the clock after a cycle in which grant and bus-idle are both high, and request is low during every clock in which frame is high.
- R3: The address phase drives frame=1, irdy=0, ad_oe=1, AD = the head entry's address and command/byte-enable = 4'b0111 (memory write). It is always followed immediately by a data phase, which has irdy=1, AD = the entry data and command/byte-enable = the bitwise inverse of the entry's active-high byte enables.
- R4: A queued entry whose address equals the previous entry's address plus 4 is sent as the next data phase of the same transaction, with no new address phase. This applies when the entry is already queued at the clock where the previous data phase is set up.
- R5: An entry is removed from the queue only on a clock with irdy and trdy both high. Entries are transferred exactly once, in push order.
- R6: While irdy is high and trdy is low, AD, command/byte-enable, frame and irdy keep their values on the next clock.
- R7: The final data phase of a transaction has frame=0 and irdy=1 until trdy. Once frame has dropped it is not raised again within the transaction. The clock after the final transfer is a turnaround with frame, irdy and ad_oe all low.
- R8: A next entry whose address does not follow the previous one ends the transaction. That entry gets its own address phase, which comes no earlier than the clock after the turnaround.
- R9: After reset, frame, irdy, request and ad_oe are low and the queue accepts writes (wr_ready=1).
- R10: When the queue holds DEPTH entries, wr_ready is low and a write offered then is dropped and never appears on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host offers a posted write |
| wr_ready | output | 1 | Queue has room; the offer is taken when both are high |
| wr_addr | input | 32 | Doubleword address of the posted write |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables, active high |
| pci_gnt | input | 1 | Bus grant (held high while the bus is parked here) |
| pci_bus_idle | input | 1 | Bus observed idle (no frame, no irdy from anyone) |
| pci_trdy | input | 1 | Target ready |
| pci_req | output | 1 | Bus request |
| pci_frame | output | 1 | Frame, active high |
| pci_irdy | output | 1 | Initiator ready, active high |
| pci_ad | output | 32 | Multiplexed address/data |
| pci_ad_oe | output | 1 | Enable for AD and command/byte-enable drivers |
| pci_cbe | output | 4 | Command in the address phase, inverted byte enables in data phases |

## Verification
The bench aims at burst boundaries: runs of sequential addresses broken by a jump, and a jump back to an address that is numerically lower. A design that merged on equal or non-incrementing addresses, or that decided merging from the wrong queue slot, would show either a missing address phase or one too many. Random target wait states check that the data on AD and the queue position stay fixed while trdy is low; popping on irdy alone would skip or repeat data words. The bench also covers a parked start where request must never rise, a granted but busy bus on which no transaction may start, and an overfilled queue in which a refused write must not reach the bus.

// File: rtl/pwd_pkg.sv
`timescale 1ns/1ps
package pwd_pkg;

  localparam int unsigned AD_W  = 32;
  localparam int unsigned BE_W  = AD_W / 8;
  localparam logic [BE_W-1:0] CMD_MEM_WRITE = 4'b0111;

  typedef struct packed {
    logic [AD_W-1:0] addr;
    logic [AD_W-1:0] data;
    logic [BE_W-1:0] be;
  } post_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARB  = 3'd1,
    ST_ADDR = 3'd2,
    ST_DATA = 3'd3,
    ST_LAST = 3'd4,
    ST_TURN = 3'd5
  } drain_state_t;

  // True when b is the doubleword that immediately follows a.
  function automatic logic is_next_dword(input logic [AD_W-1:0] a,
                                         input logic [AD_W-1:0] b);
    return b == (a + AD_W'(BE_W));
  endfunction

  // Data-phase byte enables on the bus are the inverse of the stored ones.
  function automatic logic [BE_W-1:0] be_to_bus(input logic [BE_W-1:0] be);
    return ~be;
  endfunction

endpackage

// File: rtl/pwd_queue.sv
`timescale 1ns/1ps
module pwd_queue
  import pwd_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LOOK  = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            push_valid,
  input  post_entry_t                     push_entry,
  output logic                            push_ready,
  input  logic                            pop,
  output post_entry_t                     head,
  output logic [AD_W-1:0]                 ahead_addr [LOOK],
  output logic [$clog2(DEPTH+1)-1:0]      level,
  output logic [$clog2(DEPTH)-1:0]        rd_ptr
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  post_entry_t     mem [DEPTH];
  logic [AW-1:0]   wr_ptr;
  logic            do_push;
  logic            do_pop;

  function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] p,
                                             input int unsigned k);
    int unsigned s;
    s = int'(p) + k;
    if (s >= DEPTH) s = s - DEPTH;
    return AW'(s);
  endfunction

  assign push_ready = (level != CW'(DEPTH));
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop && (level != '0);

  assign head = mem[rd_ptr];

  generate
    for (genvar t = 0; t < LOOK; t++) begin : g_look
      assign ahead_addr[t] = mem[wrap_add(rd_ptr, t + 1)].addr;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wrap_add(wr_ptr, 1);
      if (do_pop)  rd_ptr <= wrap_add(rd_ptr, 1);
      level <= level + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_entry;
  end

endmodule

// File: rtl/pwd_burst_ctrl.sv
`timescale 1ns/1ps
module pwd_burst_ctrl
  import pwd_pkg::*;
#(
  parameter int unsigned CW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   level,
  input  logic [AD_W-1:0] head_addr,
  input  logic [AD_W-1:0] look1_addr,
  input  logic [AD_W-1:0] look2_addr,
  input  logic            gnt,
  input  logic            bus_idle,
  input  logic            trdy,
  output drain_state_t    state,
  output logic            pop,
  output logic            req,
  output logic            frame,
  output logic            irdy
);

  drain_state_t state_nx;

  // Named events for the checker and for reading the FSM.
  logic bus_ours;         // grant present on an idle bus
  logic xfer_accept;      // a data phase completes this clock
  logic chain_from_addr;  // the first data phase is not the last
  logic chain_from_data;  // the phase after this one is not the last

  assign bus_ours        = gnt && bus_idle;
  assign irdy            = (state == ST_DATA) || (state == ST_LAST);
  assign frame           = (state == ST_ADDR) || (state == ST_DATA);
  assign req             = (state == ST_ARB);
  assign xfer_accept     = irdy && trdy;
  assign pop             = xfer_accept;
  assign chain_from_addr = (level >= CW'(2)) && is_next_dword(head_addr, look1_addr);
  assign chain_from_data = (level >= CW'(3)) && is_next_dword(look1_addr, look2_addr);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (level != '0) state_nx = bus_ours ? ST_ADDR : ST_ARB;
      ST_ARB:  if (bus_ours)    state_nx = ST_ADDR;
      ST_ADDR: state_nx = chain_from_addr ? ST_DATA : ST_LAST;
      ST_DATA: if (xfer_accept) state_nx = chain_from_data ? ST_DATA : ST_LAST;
      ST_LAST: if (xfer_accept) state_nx = ST_TURN;
      ST_TURN: state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

endmodule

// File: rtl/pwd_bus_drive.sv
`timescale 1ns/1ps
module pwd_bus_drive
  import pwd_pkg::*;
(
  input  drain_state_t    state,
  input  post_entry_t     head,
  output logic [AD_W-1:0] ad,
  output logic [BE_W-1:0] cbe,
  output logic            ad_oe
);

  logic addr_phase;
  logic data_phase;

  assign addr_phase = (state == ST_ADDR);
  assign data_phase = (state == ST_DATA) || (state == ST_LAST);
  assign ad_oe      = addr_phase || data_phase;

  always_comb begin
    ad  = '0;
    cbe = '0;
    if (addr_phase) begin
      ad  = head.addr;
      cbe = CMD_MEM_WRITE;
    end else if (data_phase) begin
      ad  = head.data;
      cbe = be_to_bus(head.be);
    end
  end

endmodule

// File: rtl/pwd_drain_engine.sv
`timescale 1ns/1ps
module pwd_drain_engine
  import pwd_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [31:0]     wr_addr,
  input  logic [31:0]     wr_data,
  input  logic [3:0]      wr_be,
  input  logic            pci_gnt,
  input  logic            pci_bus_idle,
  input  logic            pci_trdy,
  output logic            pci_req,
  output logic            pci_frame,
  output logic            pci_irdy,
  output logic [31:0]     pci_ad,
  output logic            pci_ad_oe,
  output logic [3:0]      pci_cbe
);

  localparam int unsigned AW   = $clog2(DEPTH);
  localparam int unsigned CW   = $clog2(DEPTH + 1);
  localparam int unsigned LOOK = 2;

  post_entry_t     in_entry;
  post_entry_t     head;
  logic [AD_W-1:0] ahead_addr [LOOK];
  logic [CW-1:0]   level;
  logic [AW-1:0]   rd_ptr;
  logic            pop;
  drain_state_t    state;

  assign in_entry = '{addr: wr_addr, data: wr_data, be: wr_be};

  pwd_queue #(.DEPTH(DEPTH), .LOOK(LOOK)) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (wr_valid),
    .push_entry (in_entry),
    .push_ready (wr_ready),
    .pop        (pop),
    .head       (head),
    .ahead_addr (ahead_addr),
    .level      (level),
    .rd_ptr     (rd_ptr)
  );

  pwd_burst_ctrl #(.CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .level      (level),
    .head_addr  (head.addr),
    .look1_addr (ahead_addr[0]),
    .look2_addr (ahead_addr[1]),
    .gnt        (pci_gnt),
    .bus_idle   (pci_bus_idle),
    .trdy       (pci_trdy),
    .state      (state),
    .pop        (pop),
    .req        (pci_req),
    .frame      (pci_frame),
    .irdy       (pci_irdy)
  );

  pwd_bus_drive u_drive (
    .state (state),
    .head  (head),
    .ad    (pci_ad),
    .cbe   (pci_cbe),
    .ad_oe (pci_ad_oe)
  );

endmodule

// File: rtl/pwd_checks.sv
`timescale 1ns/1ps
module pwd_checks #(
  parameter int unsigned DEPTH = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         wr_valid,
  input logic                         wr_ready,
  input logic                         gnt,
  input logic                         bus_idle,
  input logic                         trdy,
  input logic                         req,
  input logic                         frame,
  input logic                         irdy,
  input logic [31:0]                  ad,
  input logic                         ad_oe,
  input logic [3:0]                   cbe,
  input logic [$clog2(DEPTH)-1:0]     rd_ptr,
  input logic [$clog2(DEPTH+1)-1:0]   level
);

  assert_start_on_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame) |-> $past(gnt && bus_idle));

  assert_no_req_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame |-> !req);

  assert_addr_command_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame && !irdy) |-> (cbe == 4'b0111 && ad_oe));

  assert_addr_then_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame && !irdy) |=> irdy);

  assert_pop_on_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ptr != $past(rd_ptr)) |-> $past(irdy && trdy));

  assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy && !trdy) |=> (irdy && $stable(ad) && $stable(cbe) && $stable(frame)));

  assert_frame_stays_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy && !frame) |=> !frame);

  assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy && !frame && trdy) |=> (!irdy && !frame && !ad_oe));

  assert_full_no_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (level <= $past(level)));

endmodule

bind pwd_drain_engine pwd_checks #(.DEPTH(DEPTH)) u_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .gnt      (pci_gnt),
  .bus_idle (pci_bus_idle),
  .trdy     (pci_trdy),
  .req      (pci_req),
  .frame    (pci_frame),
  .irdy     (pci_irdy),
  .ad       (pci_ad),
  .ad_oe    (pci_ad_oe),
  .cbe      (pci_cbe),
  .rd_ptr   (rd_ptr),
  .level    (level)
);

// File: tb/tb_pwd_drain_engine.sv
`timescale 1ns/1ps
module tb_pwd_drain_engine;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic        pci_gnt = 1'b0;
  logic        pci_bus_idle = 1'b1;
  logic        pci_trdy = 1'b1;
  logic        pci_req, pci_frame, pci_irdy, pci_ad_oe;
  logic [31:0] pci_ad;
  logic [3:0]  pci_cbe;

  always #10 clk = ~clk;

  pwd_drain_engine #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .pci_gnt(pci_gnt), .pci_bus_idle(pci_bus_idle), .pci_trdy(pci_trdy),
    .pci_req(pci_req), .pci_frame(pci_frame), .pci_irdy(pci_irdy),
    .pci_ad(pci_ad), .pci_ad_oe(pci_ad_oe), .pci_cbe(pci_cbe)
  );

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    logic [3:0]  be;
    bit          starts;
  } exp_t;

  exp_t        sb [$];
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          have_prev = 0;
  logic [31:0] prev_a = '0;
  bit          wait_mode = 0;
  logic [7:0]  lfsr = 8'hA5;
  bit          watch_req = 0;
  int          req_seen = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // Driver: offer one write; on acceptance the expected item joins the scoreboard.
  task automatic post(input logic [31:0] a, input logic [31:0] d,
                      input logic [3:0] be, output bit taken);
    exp_t e;
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    @(negedge clk);
    taken = wr_ready;
    @(posedge clk); #1;
    wr_valid = 1'b0;
    if (taken) begin
      e.a = a; e.d = d; e.be = be;
      e.starts = !(have_prev && a == prev_a + 32'd4);
      sb.push_back(e);
      have_prev = 1; prev_a = a;
    end
  endtask

  task automatic new_batch();
    have_prev = 0;
  endtask

  task automatic wait_drain(input string rq);
    int n = 0;
    while ((sb.size() != 0 || pci_frame || pci_irdy) && n < 600) begin
      @(negedge clk); n++;
    end
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, rq, "scoreboard drained", 32'(sb.size()), 0);
  endtask

  // Target: trdy always high, or pseudo-random wait states.
  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      pci_trdy = wait_mode ? (lfsr[0] & ~lfsr[2]) | lfsr[5] : 1'b1;
    end
  end

  // Monitor: checks every bus cycle against the scoreboard.
  logic [31:0] cur_addr = '0;
  bit          seen_addr = 0;
  bit          prev_wait = 0;
  bit          chk_turn = 0;
  bit          prev_ours = 0;
  logic [31:0] p_ad;
  logic [3:0]  p_cbe;
  logic        p_frame;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (watch_req && pci_req) req_seen++;
        if (chk_turn) begin
          chk(!pci_frame && !pci_irdy && !pci_ad_oe, "R7", "turnaround idle",
              {29'd0, pci_frame, pci_irdy, pci_ad_oe}, 0);
          chk_turn = 0;
        end
        if (prev_wait) begin
          chk(pci_irdy && pci_ad == p_ad && pci_cbe == p_cbe && pci_frame == p_frame,
              "R6", "hold during wait", pci_ad, p_ad);
        end
        prev_wait = 0;
        if (pci_frame && !pci_irdy) begin
          chk(prev_ours, "R2", "address phase after grant and idle", 0, 1);
          chk(!pci_req, "R2", "request low in frame", 32'(pci_req), 0);
          chk(pci_cbe == 4'b0111 && pci_ad_oe, "R3", "memory write command",
              32'(pci_cbe), 32'h7);
          if (sb.size() == 0) chk(0, "R5", "address phase with nothing queued", pci_ad, 0);
          else begin
            chk(pci_ad == sb[0].a, "R3", "address on AD", pci_ad, sb[0].a);
            chk(sb[0].starts, "R4", "no address phase inside a burst", pci_ad, sb[0].a);
          end
          cur_addr = pci_ad; seen_addr = 1;
        end
        if (pci_irdy && pci_trdy) begin
          if (sb.size() == 0) chk(0, "R10", "transfer with nothing expected", pci_ad, 0);
          else begin
            exp_t e;
            bit exp_frame;
            e = sb.pop_front();
            chk(pci_ad == e.d, "R5", "data word in order", pci_ad, e.d);
            chk(pci_cbe == ~e.be, "R3", "inverted byte enables", 32'(pci_cbe), 32'(~e.be));
            chk(cur_addr == e.a, "R4", "burst address", cur_addr, e.a);
            if (!seen_addr) chk(!e.starts, "R8", "new address phase after jump", e.a, 0);
            exp_frame = (sb.size() != 0) && !sb[0].starts;
            chk(pci_frame == exp_frame, "R7", "frame on data phase",
                32'(pci_frame), 32'(exp_frame));
            if (!pci_frame) chk_turn = 1;
          end
          seen_addr = 0;
          cur_addr = cur_addr + 32'd4;
        end else if (pci_irdy) begin
          prev_wait = 1; p_ad = pci_ad; p_cbe = pci_cbe; p_frame = pci_frame;
        end
        prev_ours = pci_gnt && pci_bus_idle;
      end
    end
  end

  bit done = 0;
  initial begin
    #(20 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit tk;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(!pci_frame && !pci_irdy && !pci_req && !pci_ad_oe, "R9", "outputs idle",
        {28'd0, pci_frame, pci_irdy, pci_req, pci_ad_oe}, 0);
    chk(wr_ready, "R9", "queue ready", 32'(wr_ready), 1);

    // R1 parked start: grant already held, single write
    pci_gnt = 1'b1; watch_req = 1; req_seen = 0;
    new_batch();
    post(32'h0000_0100, 32'hDEAD_BEEF, 4'b1111, tk);
    wait_drain("R1");
    chk(req_seen == 0, "R1", "no request when parked", 32'(req_seen), 0);
    watch_req = 0;

    // R2/R4 ungranted burst of four sequential writes
    pci_gnt = 1'b0; new_batch();
    for (int i = 0; i < 4; i++) post(32'h0000_1000 + 32'(i * 4), 32'h1111_0000 + 32'(i), 4'b1111, tk);
    @(negedge clk);
    chk(pci_req, "R2", "request while waiting", 32'(pci_req), 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!pci_frame, "R2", "no frame without grant", 32'(pci_frame), 0);
    end
    @(posedge clk); #1 pci_gnt = 1'b1;
    wait_drain("R4");

    // R6 random wait states on a sequential run with mixed byte enables
    pci_gnt = 1'b0; wait_mode = 1; new_batch();
    for (int i = 0; i < 5; i++) post(32'h0000_4000 + 32'(i * 4), 32'hA5A5_0000 ^ 32'(i * 7), 4'(i + 3), tk);
    @(posedge clk); #1 pci_gnt = 1'b1;
    wait_drain("R6");

    // R8 breaks: jump forward, run, then jump back to a lower address
    pci_gnt = 1'b0; new_batch();
    post(32'h0000_2000, 32'h0000_0A01, 4'b0001, tk);
    post(32'h0000_2004, 32'h0000_0A02, 4'b0010, tk);
    post(32'h0000_3000, 32'h0000_0A03, 4'b0100, tk);
    post(32'h0000_3004, 32'h0000_0A04, 4'b1000, tk);
    post(32'h0000_3008, 32'h0000_0A05, 4'b1100, tk);
    post(32'h0000_2010, 32'h0000_0A06, 4'b0011, tk);
    post(32'h0000_2010, 32'h0000_0A07, 4'b1111, tk);
    @(posedge clk); #1 pci_gnt = 1'b1;
    wait_drain("R8");
    wait_mode = 0;

    // R2 granted but busy bus: nothing may start
    pci_bus_idle = 1'b0; new_batch();
    post(32'h0000_5000, 32'h0000_5A00, 4'b1111, tk);
    post(32'h0000_5004, 32'h0000_5A01, 4'b1111, tk);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!pci_frame && !pci_ad_oe, "R2", "no start on busy bus", 32'(pci_frame), 0);
    end
    @(posedge clk); #1 pci_bus_idle = 1'b1;
    wait_drain("R2");

    // R10 overfill: DEPTH accepted, the rest refused and never seen
    pci_gnt = 1'b0; new_batch();
    for (int i = 0; i < DEPTH + 2; i++) begin
      post(32'h0000_8000 + 32'(i * 4), 32'hC0DE_0000 + 32'(i), 4'b1111, tk);
      chk(tk == (i < DEPTH), "R10", "write acceptance", 32'(tk), 32'(i < DEPTH));
    end
    @(posedge clk); #1 pci_gnt = 1'b1;
    wait_drain("R10");
    repeat (5) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule